// File: doc/BRIEF.md
# Boundary-Scan Pin Cell Ring

This block places a serial ring of test cells around a row of bidirectional pins. Each pin owns three cells: one that watches the pad's input value, one that holds a value for the pad's output and one that holds a value for the pad's output enable. Every cell has a first stage that either captures a parallel value or takes the bit from its upstream neighbour, so the whole ring forms one shift path from a serial input to a serial output. The output and output-enable cells also have a second stage, loaded only on an update strobe, that can drive the pad.

A test-port controller outside this block drives the capture, shift and update strobes and the mode inputs. In normal mode the core's output and output-enable values reach the pads unchanged, and capture and shift still work, so the pad states can be sampled and a pattern can be preloaded while the chip runs. In external-test mode the update stages take over the pads. A separate high-impedance control forces every pad output enable low in any mode.

Internally the three strobes are reduced to one cell operation (hold, capture or shift), held in an enumerated type and chosen with capture taking priority.

Top module: `bscan_ring`

## Requirements
- R1: While rst_n is low, every capture/shift stage and every update stage clears to 0, so scan_out reads 0 and, in external-test mode, every pad_oe bit reads 0.
- R2: With mode_extest at 0, pad_out equals core_out and pad_oe equals core_oe (unless highz is set), whatever the strobes do.
- R3: On a clock edge with capture_en at 1, pin p's input cell loads pad_in[p], its output cell loads core_out[p] and its enable cell loads core_oe[p]. Capture wins over shift when both strobes are high.
- R4: On a clock edge with shift_en at 1 and capture_en at 0, every cell moves one place toward scan_out. scan_in enters pin NUM_PINS-1's enable cell. Within a pin the order is enable cell, output cell, input cell, and pin p's input cell feeds pin p-1's enable cell. scan_out is the registered content of pin 0's input cell.
- R5: The update stages change only on a clock edge with update_en at 1. That edge copies each pin's output and enable cells into them, so the pads stay steady during capture and shift.
- R6: With mode_extest at 1, pad_out[p] equals pin p's output update stage and pad_oe[p] equals its enable update stage (unless highz is set).
- R7: With highz at 1, every pad_oe bit is 0 in both modes.
- R8: On a clock edge with no strobe high, the ring holds its contents; scan_out and the pads do not move while pad_in changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock; all stages act on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of all stages |
| mode_extest | input | 1 | 1: update stages drive the pads; 0: core drives the pads |
| highz | input | 1 | 1: force every pad output enable to 0 |
| capture_en | input | 1 | Capture strobe: load parallel values into the ring |
| shift_en | input | 1 | Shift strobe: move the ring one place toward scan_out |
| update_en | input | 1 | Update strobe: copy ring contents into the update stages |
| scan_in | input | 1 | Serial data entering the ring |
| scan_out | output | 1 | Serial data leaving the ring |
| core_out | input | NUM_PINS | Output data from the core logic |
| core_oe | input | NUM_PINS | Output enables from the core logic |
| pad_in | input | NUM_PINS | Values seen at the pads |
| pad_out | output | NUM_PINS | Output data toward the pad drivers |
| pad_oe | output | NUM_PINS | Output enables toward the pad drivers |

## Verification
A corrupted capture/shift stage shows up on scan_out after as many shift cycles as there are cells between it and the serial output. Shifting the full ring after every capture and preload exposes each stage within 3*NUM_PINS cycles. A wrong update stage shows up on the pads in the same cycle that external-test mode is selected. A broken mode or high-impedance override shows up on the pads in the cycle the control changes. The bench compares scan_out, pad_out and pad_oe with its model on every clock, so any fault is reported in the first cycle it reaches a port.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
    // operation applied to the capture/shift stage of every cell
    typedef enum logic [1:0] {
        OP_HOLD    = 2'd0,
        OP_CAPTURE = 2'd1,
        OP_SHIFT   = 2'd2
    } cell_op_e;

    localparam int CELLS_PER_PIN = 3;
endpackage

// File: rtl/bscan_cell.sv
module bscan_cell
    import bscan_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  cell_op_e op,
    input  logic     par_in,
    input  logic     ser_in,
    output logic     ser_out
);
    // capture/shift stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ser_out <= 1'b0;
        end else begin
            unique case (op)
                OP_CAPTURE: ser_out <= par_in;
                OP_SHIFT:   ser_out <= ser_in;
                default:    ser_out <= ser_out;
            endcase
        end
    end
endmodule

// File: rtl/bscan_pin.sv
module bscan_pin
    import bscan_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  cell_op_e op,
    input  logic     upd_en,
    input  logic     extest,
    input  logic     highz,
    input  logic     ser_in,
    output logic     ser_out,
    input  logic     core_out,
    input  logic     core_oe,
    input  logic     pad_in,
    output logic     pad_out,
    output logic     pad_oe
);
    logic oe_q, out_q;
    logic upd_out, upd_oe;

    // ring order inside one pin: enable -> output -> input
    bscan_cell u_oe (
        .clk(clk), .rst_n(rst_n), .op(op),
        .par_in(core_oe), .ser_in(ser_in), .ser_out(oe_q)
    );
    bscan_cell u_out (
        .clk(clk), .rst_n(rst_n), .op(op),
        .par_in(core_out), .ser_in(oe_q), .ser_out(out_q)
    );
    bscan_cell u_in (
        .clk(clk), .rst_n(rst_n), .op(op),
        .par_in(pad_in), .ser_in(out_q), .ser_out(ser_out)
    );

    // update stages for the two driving cells; the input cell observes only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            upd_out <= 1'b0;
            upd_oe  <= 1'b0;
        end else if (upd_en) begin
            upd_out <= out_q;
            upd_oe  <= oe_q;
        end
    end

    always_comb begin
        pad_out = extest ? upd_out : core_out;
        pad_oe  = extest ? upd_oe  : core_oe;
        if (highz) begin
            pad_oe = 1'b0;
        end
    end
endmodule

// File: rtl/bscan_ring.sv
module bscan_ring
    import bscan_pkg::*;
#(
    parameter int NUM_PINS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_extest,
    input  logic                highz,
    input  logic                capture_en,
    input  logic                shift_en,
    input  logic                update_en,
    input  logic                scan_in,
    output logic                scan_out,
    input  logic [NUM_PINS-1:0] core_out,
    input  logic [NUM_PINS-1:0] core_oe,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe
);
    cell_op_e cell_op;
    logic [NUM_PINS:0] link;

    // strobe decode: capture has priority over shift
    always_comb begin
        unique casez ({capture_en, shift_en})
            2'b1?:   cell_op = OP_CAPTURE;
            2'b01:   cell_op = OP_SHIFT;
            default: cell_op = OP_HOLD;
        endcase
    end

    assign link[NUM_PINS] = scan_in;
    assign scan_out       = link[0];

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        bscan_pin u_pin (
            .clk      (clk),
            .rst_n    (rst_n),
            .op       (cell_op),
            .upd_en   (update_en),
            .extest   (mode_extest),
            .highz    (highz),
            .ser_in   (link[p+1]),
            .ser_out  (link[p]),
            .core_out (core_out[p]),
            .core_oe  (core_oe[p]),
            .pad_in   (pad_in[p]),
            .pad_out  (pad_out[p]),
            .pad_oe   (pad_oe[p])
        );
    end
endmodule

// File: rtl/bscan_ring_chk.sv
module bscan_ring_chk #(
    parameter int NUM_PINS = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                mode_extest,
    input logic                highz,
    input logic                capture_en,
    input logic                shift_en,
    input logic                update_en,
    input logic                scan_in,
    input logic                scan_out,
    input logic [NUM_PINS-1:0] core_out,
    input logic [NUM_PINS-1:0] core_oe,
    input logic [NUM_PINS-1:0] pad_in,
    input logic [NUM_PINS-1:0] pad_out,
    input logic [NUM_PINS-1:0] pad_oe
);
    assert_highz_forces_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        highz |-> (pad_oe == '0));

    assert_normal_passes_core_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_extest |-> (pad_out == core_out));

    assert_pads_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_extest && !update_en) |=> (!mode_extest || $stable(pad_out)));

    assert_oe_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_extest && !update_en && !highz) |=> (!mode_extest || highz || $stable(pad_oe)));

    assert_capture_reaches_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
        capture_en |=> (scan_out == $past(pad_in[0])));

    assert_idle_holds_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!capture_en && !shift_en) |=> $stable(scan_out));

    // unused here but part of the port set
    logic unused_ok;
    assign unused_ok = ^{scan_in, core_oe};
endmodule

bind bscan_ring bscan_ring_chk #(.NUM_PINS(NUM_PINS)) u_chk (.*);

// File: tb/bscan_ring_test.sv
module bscan_ring_test;
    localparam int NP         = 4;
    localparam int CLK_PERIOD = 10;
    localparam int L          = 3 * NP;

    logic clk = 1'b0;
    logic rst_n, mode_extest, highz, capture_en, shift_en, update_en, scan_in;
    logic scan_out;
    logic [NP-1:0] core_out, core_oe, pad_in, pad_out, pad_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    bscan_ring #(.NUM_PINS(NP)) uut (.*);

    bit mq[$];
    logic [NP-1:0] m_uo, m_uoe;
    int n_chk = 0, n_err = 0;
    string req = "R1";
    bit done = 0;

    task automatic chk(string what, logic [NP-1:0] got, logic [NP-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s %s: got %b expected %b at %0t", req, what, got, exp, $time);
        end
    endtask

    // one clock: advance the model at the edge, compare a quarter period later
    task automatic cyc();
        logic [NP-1:0] e_out, e_oe;
        @(posedge clk);
        if (!rst_n) begin
            mq.delete();
            for (int k = 0; k < L; k++) mq.push_back(1'b0);
            m_uo = '0; m_uoe = '0;
        end else begin
            if (update_en) begin
                for (int p = 0; p < NP; p++) begin
                    m_uo[p]  = mq[3*p+1];
                    m_uoe[p] = mq[3*p+2];
                end
            end
            if (capture_en) begin
                for (int p = 0; p < NP; p++) begin
                    mq[3*p]   = pad_in[p];
                    mq[3*p+1] = core_out[p];
                    mq[3*p+2] = core_oe[p];
                end
            end else if (shift_en) begin
                void'(mq.pop_front());
                mq.push_back(scan_in);
            end
        end
        #(CLK_PERIOD/4);
        e_out = mode_extest ? m_uo : core_out;
        e_oe  = highz ? '0 : (mode_extest ? m_uoe : core_oe);
        chk("scan_out", {{(NP-1){1'b0}}, scan_out}, {{(NP-1){1'b0}}, mq[0]});
        chk("pad_out", pad_out, e_out);
        chk("pad_oe", pad_oe, e_oe);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 0; mode_extest = 1; highz = 0; capture_en = 0; shift_en = 0;
        update_en = 0; scan_in = 0;
        core_out = 4'b1111; core_oe = 4'b1111; pad_in = 4'b1111;

        // R1: reset clears ring and update stages (extest shows oe at 0)
        req = "R1";
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        mode_extest = 0;

        // R2: normal mode passes core, strobes have no pad effect
        req = "R2";
        core_out = 4'b1010; core_oe = 4'b0110; pad_in = 4'b0011;
        shift_en = 1;
        for (int k = 0; k < 5; k++) begin scan_in = k[0]; cyc(); end
        shift_en = 0; update_en = 1; cyc(); update_en = 0;
        core_out = 4'b0101; core_oe = 4'b1001; cyc();

        // R3: capture pads and core values
        req = "R3";
        pad_in = 4'b0110; core_out = 4'b0011; core_oe = 4'b1100;
        capture_en = 1; cyc(); capture_en = 0;

        // R4: shift the whole ring out in order
        req = "R4";
        shift_en = 1;
        for (int k = 0; k < L; k++) begin
            scan_in = 1'b0; pad_in = 4'(k); cyc();
        end
        shift_en = 0;

        // R5: preload a pattern, then update
        req = "R5";
        shift_en = 1;
        for (int k = 0; k < L; k++) begin
            scan_in = (12'hA6C >> k) & 1'b1; cyc();
        end
        shift_en = 0; update_en = 1; cyc(); update_en = 0;

        // R6: external test drives pads from update stages
        req = "R6";
        mode_extest = 1; core_out = 4'b0000; core_oe = 4'b0000;
        repeat (2) cyc();

        // R5: shifting in extest leaves pads steady until update
        req = "R5";
        shift_en = 1;
        for (int k = 0; k < L; k++) begin
            scan_in = (12'h3B5 >> k) & 1'b1; cyc();
        end
        shift_en = 0; cyc();
        req = "R6";
        update_en = 1; cyc(); update_en = 0; cyc();

        // R7: high-impedance override in both modes
        req = "R7";
        highz = 1; repeat (2) cyc();
        mode_extest = 0; core_oe = 4'b1111; repeat (2) cyc();
        highz = 0; cyc();

        // R3: capture beats shift
        req = "R3";
        pad_in = 4'b1001; core_out = 4'b1110; core_oe = 4'b0101;
        capture_en = 1; shift_en = 1; scan_in = 1; cyc();
        capture_en = 0; shift_en = 0;

        // R8: idle cycles hold the ring while pad_in moves
        req = "R8";
        for (int k = 0; k < 3; k++) begin pad_in = ~pad_in; cyc(); end

        // R4: drain again to confirm the held contents
        req = "R4";
        shift_en = 1;
        for (int k = 0; k < L; k++) begin scan_in = 1'b1; cyc(); end
        shift_en = 0;

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule